// File: doc/BRIEF.md
# Lane-Select Read-Modify-Write Controller for a Bit-Sliced Pixel Buffer

This block writes one permuted pixel into a buffer made of eight SRAMs, each four bits wide. Each SRAM word holds four independent one-bit logical memories, one per bit lane. SRAM k carries logical memories k, k+8, k+16 and k+24 on lanes 0 to 3. A pixel therefore changes exactly one bit in each of the eight SRAM words at one address. The other three bits of each word must keep their contents. The block does this with a read-modify-write: it reads the 32-bit word at the address, replaces the selected lane of every SRAM with the new pixel bit, and writes the word back.

An upstream address generator and bit shuffler supply the address, the eight shuffled bits (one per SRAM) and a two-bit block-group index. The block-group index is bits 4:3 of the picture block number, and it selects the lane. A 2-to-4 decoder turns the index into per-lane mux selects. The merged word is held in a register before it drives the SRAM data bus. One transaction takes four busy cycles. An offer made while the block is busy is refused through the ready signal, so no pixel is lost without notice.

The controller is a five-state machine:
- `ST_IDLE`: ready, nothing driven. It moves to `ST_ADDR` on valid.
- `ST_ADDR`: address presented with output enable on. It always moves to `ST_CAPT`.
- `ST_CAPT`: output enable still on. The read data is merged and registered at the end of this cycle. It always moves to `ST_DRIVE`.
- `ST_DRIVE`: the merged word drives the bus. It always moves to `ST_WRITE`.
- `ST_WRITE`: the bus is still driven and write enable is pulsed. It always moves back to `ST_IDLE`.

Top module: `pixbuf_rmw`

## Requirements
- R1: After reset, `busy`, `sram_oe`, `sram_we` and `sram_drive` are 0 and `pix_ready` is 1.
- R2: After a pixel is accepted (`pix_valid` and `pix_ready` high at a clock edge), `busy` is high for exactly four cycles.
  - `sram_oe` is high in the first two of these cycles.
  - `sram_drive` is high in the last two.
  - `sram_we` is high only in the fourth.
- R3: `sram_addr` equals the accepted `pix_addr` and stays unchanged during all four busy cycles.
- R4: The written word replaces lane `blk_grp` of every SRAM. Bit `4*k + blk_grp` of `sram_wdata` equals `pix_bits[k]`, for k = 0..7.
- R5: The other three lanes of every SRAM word equal the values read at the same address, so each 4-bit word differs from the read word in at most one bit.
- R6: `pix_ready` is low whenever `busy` is high. A `pix_valid` offered during busy cycles starts nothing and does not change the address or the written data.
- R7: `sram_we` is never high together with `sram_oe`, and is high only while `sram_drive` is high. The driven data is stable while it is driven.
- R8: In the cycle after the write pulse, the block is idle and ready again. A new pixel may be accepted at the very next edge.
- R9: `sram_rdata` is sampled only at the end of the second busy cycle. Its value while `sram_oe` is low has no effect on the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is offered |
| pix_ready | output | 1 | The block can accept a pixel this cycle |
| pix_addr | input | 14 | Buffer address for the pixel |
| pix_bits | input | 8 | Shuffled pixel bits, bit k for SRAM k |
| blk_grp | input | 2 | Block-group index (block number bits 4:3), selects the lane |
| sram_rdata | input | 32 | Read data, SRAM k on bits 4k+3..4k |
| sram_addr | output | 14 | SRAM address, shared by all eight SRAMs |
| sram_wdata | output | 32 | Registered merged write data |
| sram_drive | output | 1 | Write data bus is driven |
| sram_oe | output | 1 | SRAM output enable |
| sram_we | output | 1 | SRAM write enable pulse |
| busy | output | 1 | A read-modify-write is in progress |

## Verification
The embedded assertions check the following on every cycle:
- the strobe ordering and exclusivity (R7),
- the refusal of offers while busy (R6),
- the held address (R3),
- the single-cycle write pulse followed by return to idle (R2, R8),
- the at-most-one-bit change per 4-bit word (R5).

Only the bench's scenarios can show the following:
- that the correct lane is the one replaced for each block-group value (R4),
- that the untouched lanes hold what the buffer contained,
- that read data seen outside the sampling cycle is ignored (R9).

To show these, the bench runs a memory model that returns garbage whenever output enable is low. It sweeps all four lanes against several bit patterns, with a distinct background word at each address.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_CAPT  = 3'd2,
        ST_DRIVE = 3'd3,
        ST_WRITE = 3'd4
    } rmw_state_t;

endpackage

// File: rtl/rmw_fsm.sv
module rmw_fsm
    import rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pix_valid,
    output logic pix_ready,
    output logic accept,
    output logic cap_en,
    output logic oe,
    output logic drive,
    output logic we,
    output logic busy
);

    rmw_state_t state_q;
    rmw_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        pix_ready = 1'b0;
        accept    = 1'b0;
        cap_en    = 1'b0;
        oe        = 1'b0;
        drive     = 1'b0;
        we        = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy      = 1'b0;
                pix_ready = 1'b1;
                if (pix_valid) begin
                    accept  = 1'b1;
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                oe      = 1'b1;
                state_d = ST_CAPT;
            end
            ST_CAPT: begin
                oe      = 1'b1;
                cap_en  = 1'b1;
                state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                drive   = 1'b1;
                state_d = ST_WRITE;
            end
            ST_WRITE: begin
                drive   = 1'b1;
                we      = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                busy    = 1'b0;
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/lane_decoder.sv
module lane_decoder #(
    parameter int LANES = 4,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LANES-1:0] lane_oh
);

    always_comb begin
        lane_oh = '0;
        for (int l = 0; l < LANES; l++) begin
            if (sel == SEL_W'(l)) begin
                lane_oh[l] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bit_merge.sv
module bit_merge #(
    parameter int NUM_SRAM = 8,
    parameter int LANES    = 4,
    localparam int WORD_W  = NUM_SRAM * LANES
) (
    input  logic [WORD_W-1:0]   rd_word,
    input  logic [NUM_SRAM-1:0] new_bits,
    input  logic [LANES-1:0]    lane_oh,
    output logic [WORD_W-1:0]   merged
);

    for (genvar k = 0; k < NUM_SRAM; k++) begin : g_sram
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign merged[k*LANES + l] = lane_oh[l] ? new_bits[k] : rd_word[k*LANES + l];
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_SRAM; k++) begin
            AST_ONE_BIT_PER_WORD: assert ($countones(merged[k*LANES +: LANES] ^ rd_word[k*LANES +: LANES]) <= 1); // R5
        end
    end

endmodule

// File: rtl/pixbuf_rmw.sv
module pixbuf_rmw #(
    parameter int NUM_SRAM = 8,
    parameter int LANES    = 4,
    parameter int ADDR_W   = 14,
    localparam int WORD_W  = NUM_SRAM * LANES,
    localparam int SEL_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_valid,
    output logic                pix_ready,
    input  logic [ADDR_W-1:0]   pix_addr,
    input  logic [NUM_SRAM-1:0] pix_bits,
    input  logic [SEL_W-1:0]    blk_grp,
    input  logic [WORD_W-1:0]   sram_rdata,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic [WORD_W-1:0]   sram_wdata,
    output logic                sram_drive,
    output logic                sram_oe,
    output logic                sram_we,
    output logic                busy
);

    logic                accept;
    logic                cap_en;
    logic [ADDR_W-1:0]   addr_q;
    logic [NUM_SRAM-1:0] bits_q;
    logic [SEL_W-1:0]    grp_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [LANES-1:0]    lane_oh;
    logic [WORD_W-1:0]   merged;

    rmw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .accept    (accept),
        .cap_en    (cap_en),
        .oe        (sram_oe),
        .drive     (sram_drive),
        .we        (sram_we),
        .busy      (busy)
    );

    lane_decoder #(.LANES(LANES)) u_dec (
        .sel     (grp_q),
        .lane_oh (lane_oh)
    );

    bit_merge #(.NUM_SRAM(NUM_SRAM), .LANES(LANES)) u_merge (
        .rd_word  (sram_rdata),
        .new_bits (bits_q),
        .lane_oh  (lane_oh),
        .merged   (merged)
    );

    // request capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            bits_q <= '0;
            grp_q  <= '0;
        end else if (accept) begin
            addr_q <= pix_addr;
            bits_q <= pix_bits;
            grp_q  <= blk_grp;
        end
    end

    // merged word registered before it reaches the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (cap_en) begin
            wdata_q <= merged;
        end
    end

    assign sram_addr  = addr_q;
    assign sram_wdata = wdata_q;

    AST_WE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (sram_drive && !sram_oe)); // R7
    AST_OE_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_oe && sram_drive)); // R7
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_drive && $past(sram_drive)) |-> $stable(sram_wdata)); // R7
    AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pix_ready); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sram_addr)); // R3
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |=> (!sram_we && !busy && pix_ready)); // R8
    AST_OE_TO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(sram_oe)) |-> (sram_drive && !sram_we)); // R2

endmodule

// File: tb/pixbuf_rmw_tb.sv
module pixbuf_rmw_tb;

    localparam int NS = 8;
    localparam int LN = 4;
    localparam int AW = 14;
    localparam int WW = NS * LN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0;
    logic          pix_ready;
    logic [AW-1:0] pix_addr = '0;
    logic [NS-1:0] pix_bits = '0;
    logic [1:0]    blk_grp = '0;
    logic [WW-1:0] sram_rdata;
    logic [AW-1:0] sram_addr;
    logic [WW-1:0] sram_wdata;
    logic          sram_drive, sram_oe, sram_we, busy;

    logic [WW-1:0] mem [0:(1<<AW)-1];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pixbuf_rmw u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_ready  (pix_ready),
        .pix_addr   (pix_addr),
        .pix_bits   (pix_bits),
        .blk_grp    (blk_grp),
        .sram_rdata (sram_rdata),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_drive (sram_drive),
        .sram_oe    (sram_oe),
        .sram_we    (sram_we),
        .busy       (busy)
    );

    // SRAM model: garbage on the read bus when output enable is low (R9)
    assign sram_rdata = sram_oe ? mem[sram_addr] : ~mem[sram_addr] ^ 32'h5A5A_C3C3;

    always @(posedge clk) begin
        if (sram_we) mem[sram_addr] <= sram_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] merge_exp(input logic [WW-1:0] old, input logic [NS-1:0] b, input int g);
        logic [WW-1:0] r = old;
        for (int k = 0; k < NS; k++) r[k*LN + g] = b[k];
        return r;
    endfunction

    // called at a negedge with the block idle; returns at a negedge with it idle
    task automatic do_pix(input logic [AW-1:0] a, input logic [NS-1:0] b, input int g, input logic [WW-1:0] bg);
        logic [WW-1:0] exp;
        mem[a] = bg;
        exp = merge_exp(bg, b, g);
        chk(pix_ready && !busy, "R8 ready before accept", {30'd0, busy, pix_ready}, 32'd1);
        pix_valid = 1'b1; pix_addr = a; pix_bits = b; blk_grp = 2'(g);
        @(negedge clk);
        // offers during busy cycles must be ignored (R6)
        pix_addr = ~a; pix_bits = ~b; blk_grp = 2'(g + 1);
        chk(busy && !pix_ready, "R6 busy refuses", {30'd0, busy, pix_ready}, 32'd2);
        chk(sram_oe && !sram_drive && !sram_we, "R2 cycle0 strobes",
            {29'd0, sram_oe, sram_drive, sram_we}, 32'd4);
        chk(sram_addr == a, "R3 address cycle0", 32'(sram_addr), 32'(a));
        @(negedge clk);
        chk(busy && sram_oe && !sram_drive && !sram_we, "R2 cycle1 strobes",
            {28'd0, busy, sram_oe, sram_drive, sram_we}, 32'hC);
        @(negedge clk);
        chk(busy && !sram_oe && sram_drive && !sram_we, "R2 cycle2 strobes",
            {28'd0, busy, sram_oe, sram_drive, sram_we}, 32'hA);
        chk(sram_wdata == exp, "R4 R5 R9 merged word", sram_wdata, exp);
        @(negedge clk);
        pix_valid = 1'b0;
        chk(busy && !sram_oe && sram_drive && sram_we, "R2 R7 cycle3 strobes",
            {28'd0, busy, sram_oe, sram_drive, sram_we}, 32'hB);
        chk(sram_addr == a, "R3 address cycle3", 32'(sram_addr), 32'(a));
        @(negedge clk);
        chk(!busy && pix_ready && !sram_we && !sram_oe, "R8 idle after write",
            {29'd0, busy, pix_ready, sram_we}, 32'd2);
        chk(mem[a] == exp, "R5 R6 stored word", mem[a], exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0] pats [6];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
        pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;
        repeat (3) @(negedge clk);
        chk(!busy && pix_ready && !sram_oe && !sram_we && !sram_drive, "R1 reset state",
            {27'd0, busy, pix_ready, sram_oe, sram_we, sram_drive}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && pix_ready, "R1 after reset release", {30'd0, busy, pix_ready}, 32'd1);
        for (int g = 0; g < LN; g++) begin
            for (int p = 0; p < 6; p++) begin
                logic [AW-1:0] a;
                logic [WW-1:0] bg;
                a  = AW'(g * 1237 + p * 311 + 5);
                bg = 32'h9E37_79B1 * (g * 6 + p + 1);
                do_pix(a, pats[p], g, bg);
            end
        end
        // all-ones and all-zeros backgrounds on every lane
        for (int g = 0; g < LN; g++) begin
            do_pix(AW'(16383 - g), 8'h00, g, 32'hFFFF_FFFF);
            do_pix(AW'(g), 8'hFF, g, 32'h0000_0000);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule